// File: doc/BRIEF.md
# Event-Code Triggered Delayed Pulse Generator

This block sits in a timing receiver after the serial link has been recovered into a stream of 8-bit event codes, one per frame-clock cycle. Each received code indexes a local action table. The entry says which of the pulse outputs should fire and whether an interrupt request should be raised. Every receiver loads its own table, so one code can have different effects in different receivers.

A fired output first waits a programmed delay, then drives a pulse of programmed width. Both are counted in steps of a per-output prescaler. Each output can be set active-high or active-low. The interrupt request is a one-cycle pulse with its own delay. A new trigger on an output that is still busy restarts that output from the beginning of its delay. The code 0x00 is the idle filler of the stream and never causes any action.

Top module: `evcode_pulse_gen`

## Requirements
- R1: A code of 0x00 with `code_valid` high never starts an output or the interrupt, whatever table entry 0 holds.
- R2: The table is written through `tbl_we`/`tbl_addr`/`tbl_wdata` at a clock edge and governs codes sampled at later edges. Entry bit i (i = 0..3) enables output i and bit 4 enables the interrupt. Rewriting an entry changes which outputs that code fires.
- R3: Let a non-null code be sampled at edge n, with output i enabled, delay D and prescaler P. Output i turns active right after edge n+1+D·(P+1).
- R4: Output i stays active for exactly W·(P+1) cycles, where W is its width, and then returns to its idle level.
- R5: A width of 0 produces no pulse at all.
- R6: A delay of 0 makes the output active right after edge n+1.
- R7: With its polarity bit at 0, an output idles low and pulses high. With the bit at 1, it idles high and pulses low.
- R8: The prescaler value P stretches every delay and width step to P+1 cycles, and each output has its own value.
- R9: If an output is triggered again while it is still waiting or pulsing, it restarts its full delay from the new trigger. The earlier pulse is dropped.
- R10: An enabled interrupt produces a single high cycle on `irq` right after edge n+1+Dirq, where Dirq is `irq_dly`.
- R11: While `rst` is high at a clock edge, every output returns to its idle level, `irq` goes low and any pending delay is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | `code_in` carries a received event code this cycle |
| code_in | input | 8 | Received event code |
| tbl_we | input | 1 | Action table write strobe |
| tbl_addr | input | 8 | Action table write address (event code) |
| tbl_wdata | input | 5 | Action entry: bits 3..0 output enables, bit 4 interrupt enable |
| dly_cfg | input | 64 | Per-output delay, 16 bits each, output i at bits 16i+15..16i |
| wid_cfg | input | 64 | Per-output width, 16 bits each, same packing |
| presc_cfg | input | 32 | Per-output prescaler, 8 bits each, output i at bits 8i+7..8i |
| pol_cfg | input | 4 | Per-output polarity, 1 = active-low |
| irq_dly | input | 16 | Interrupt delay in cycles |
| pulse_out | output | 4 | Pulse outputs |
| irq | output | 1 | Interrupt request pulse |

## Verification
The stimulus includes a single-output code, and a code that fires two outputs with different delays together with the interrupt. These show whether the enable bits are decoded independently and whether each output keeps its own counters. The boundary settings are zero delay, zero width, a non-zero prescaler and inverted polarity. Each is compared cycle by cycle against a window computed from the timing formula, so an off-by-one in either edge of the pulse shows up.

The remaining patterns are the null code with a fully enabled entry, a back-to-back retrigger, a table rewrite and a reset during a pending delay. They separate the filtering, restart and remapping behaviour from plain pulse generation.

// File: rtl/evp_pkg.sv
package evp_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_WAIT  = 2'd1,
    CH_PULSE = 2'd2
  } ch_state_t;
endpackage

// File: rtl/evp_act_ram.sv
module evp_act_ram #(
  parameter int AW = 8,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evp_chan.sv
module evp_chan
  import evp_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] dly,
  input  logic [CW-1:0] wid,
  input  logic [PW-1:0] presc,
  input  logic          pol,
  output logic          pin
);
  ch_state_t     st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [PW-1:0] pre, pre_n;
  logic          tick;
  logic          active;

  assign tick   = (pre == '0);
  assign active = (st == CH_PULSE);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    pre_n = pre;
    if (start) begin
      pre_n = presc;
      if (dly != '0) begin
        st_n  = CH_WAIT;
        cnt_n = dly;
      end else if (wid != '0) begin
        st_n  = CH_PULSE;
        cnt_n = wid;
      end else begin
        st_n  = CH_IDLE;
      end
    end else if (st != CH_IDLE) begin
      pre_n = tick ? presc : pre - 1'b1;
      if (tick) begin
        if (cnt == 1) begin
          if (st == CH_WAIT && wid != '0) begin
            st_n  = CH_PULSE;
            cnt_n = wid;
          end else begin
            st_n  = CH_IDLE;
          end
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= CH_IDLE;
      cnt <= '0;
      pre <= '0;
      pin <= pol;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      pre <= pre_n;
      pin <= (st_n == CH_PULSE) ^ pol;
    end
  end

  // R6
  zero_dly_chk: assert property (@(posedge clk) disable iff (rst)
    (start && dly == '0 && wid != '0) |=> active);

  // R5
  no_width_chk: assert property (@(posedge clk) disable iff (rst)
    (start && dly == '0 && wid == '0) |=> !active);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (start && dly != '0) |=> (st == CH_WAIT));

  // R4
  width_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && !$past(start)) |-> $past(tick));
endmodule

// File: rtl/evcode_pulse_gen.sv
module evcode_pulse_gen #(
  parameter int N_OUT  = 4,
  parameter int CODE_W = 8,
  parameter int CW     = 16,
  parameter int PW     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  code_valid,
  input  logic [CODE_W-1:0]     code_in,
  input  logic                  tbl_we,
  input  logic [CODE_W-1:0]     tbl_addr,
  input  logic [N_OUT:0]        tbl_wdata,
  input  logic [N_OUT*CW-1:0]   dly_cfg,
  input  logic [N_OUT*CW-1:0]   wid_cfg,
  input  logic [N_OUT*PW-1:0]   presc_cfg,
  input  logic [N_OUT-1:0]      pol_cfg,
  input  logic [CW-1:0]         irq_dly,
  output logic [N_OUT-1:0]      pulse_out,
  output logic                  irq
);
  localparam int ACT_W = N_OUT + 1;
  localparam logic [CW-1:0] IRQ_WID = CW'(1);

  logic [ACT_W-1:0] act;
  logic             hit_q;
  logic [ACT_W-1:0] fire;

  evp_act_ram #(.AW(CODE_W), .DW(ACT_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (code_in),
    .rdata (act)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= code_valid && (code_in != '0);
  end

  assign fire = hit_q ? act : '0;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    evp_chan #(.CW(CW), .PW(PW)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .start (fire[i]),
      .dly   (dly_cfg[i*CW +: CW]),
      .wid   (wid_cfg[i*CW +: CW]),
      .presc (presc_cfg[i*PW +: PW]),
      .pol   (pol_cfg[i]),
      .pin   (pulse_out[i])
    );
  end

  evp_chan #(.CW(CW), .PW(PW)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .start (fire[N_OUT]),
    .dly   (irq_dly),
    .wid   (IRQ_WID),
    .presc ('0),
    .pol   (1'b0),
    .pin   (irq)
  );

  // R1
  null_code_chk: assert property (@(posedge clk) disable iff (rst)
    (code_valid && code_in == '0) |=> !hit_q);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (pulse_out == $past(pol_cfg) && !irq));
endmodule

// File: tb/evcode_pulse_gen_bench.sv
module evcode_pulse_gen_bench;
  localparam int N = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        code_valid = 0;
  logic [7:0]  code_in = 0;
  logic        tbl_we = 0;
  logic [7:0]  tbl_addr = 0;
  logic [4:0]  tbl_wdata = 0;
  logic [63:0] dly_cfg, wid_cfg;
  logic [31:0] presc_cfg;
  logic [3:0]  pol_cfg;
  logic [15:0] irq_dly = 0;
  logic [3:0]  pulse_out;
  logic        irq;

  logic [15:0] dly_b [N];
  logic [15:0] wid_b [N];
  logic [7:0]  pre_b [N];
  logic [4:0]  tbl_m [256];

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      dly_cfg[i*16 +: 16] = dly_b[i];
      wid_cfg[i*16 +: 16] = wid_b[i];
      presc_cfg[i*8 +: 8] = pre_b[i];
    end
  end

  evcode_pulse_gen u_evcode_pulse_gen (
    .clk(clk), .rst(rst), .code_valid(code_valid), .code_in(code_in),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .dly_cfg(dly_cfg), .wid_cfg(wid_cfg), .presc_cfg(presc_cfg),
    .pol_cfg(pol_cfg), .irq_dly(irq_dly), .pulse_out(pulse_out), .irq(irq)
  );

  task automatic tbl_write(input logic [7:0] a, input logic [4:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_addr = a; tbl_wdata = d;
    tbl_m[a] = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic fire(input logic [7:0] c);
    @(negedge clk);
    code_valid = 1; code_in = c;
    @(posedge clk);
    @(negedge clk);
    code_valid = 0; code_in = 0;
  endtask

  function automatic bit win(input int i, input int k);
    int lo, hi;
    lo = 1 + int'(dly_b[i]) * (int'(pre_b[i]) + 1);
    hi = 1 + (int'(dly_b[i]) + int'(wid_b[i])) * (int'(pre_b[i]) + 1);
    return (k >= lo) && (k < hi);
  endfunction

  // Samples from the negedge right after the code edge (k = 0) onward.
  task automatic watch(input logic [4:0] mask, input int len, input string tag);
    int bad [N+1];
    logic act_e [N+1];
    logic got_e [N+1];
    logic exp_e [N+1];
    for (int i = 0; i <= N; i++) bad[i] = 0;
    for (int k = 0; k < len; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      for (int i = 0; i < N; i++) begin
        logic e;
        e = (mask[i] && win(i, k)) ^ pol_cfg[i];
        if (pulse_out[i] !== e && bad[i] == 0) begin
          act_e[i] = pulse_out[i];
          exp_e[i] = e;
          got_e[i] = 1;
        end
        if (pulse_out[i] !== e) bad[i]++;
      end
      begin
        logic e;
        e = mask[4] && (k == 1 + int'(irq_dly));
        if (irq !== e && bad[N] == 0) begin
          act_e[N] = irq;
          exp_e[N] = e;
        end
        if (irq !== e) bad[N]++;
      end
    end
    for (int i = 0; i <= N; i++) begin
      tests++;
      if (bad[i] != 0) begin
        fails++;
        $display("FAIL %s: output %0d wrong in %0d cycles (first actual %b expected %b)",
                 tag, i, bad[i], act_e[i], exp_e[i]);
      end
    end
  endtask

  task automatic t_reset_state;
    tests++;
    if (pulse_out !== 4'b0000 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R11: after reset actual %b/%b expected 0000/0", pulse_out, irq);
    end
  endtask

  task automatic t_basic;        // R2 R3 R4
    tbl_write(8'h11, 5'b00001);
    dly_b[0] = 3; wid_b[0] = 2; pre_b[0] = 0;
    fire(8'h11);
    watch(5'b00001, 12, "R3/R4 basic");
  endtask

  task automatic t_multi;        // R2 R10
    tbl_write(8'h22, 5'b10110);
    dly_b[1] = 1; wid_b[1] = 4;
    dly_b[2] = 5; wid_b[2] = 1;
    irq_dly = 2;
    fire(8'h22);
    watch(5'b10110, 14, "R2/R10 multi");
  endtask

  task automatic t_presc;        // R8
    tbl_write(8'h33, 5'b01000);
    dly_b[3] = 2; wid_b[3] = 1; pre_b[3] = 2;
    fire(8'h33);
    watch(5'b01000, 14, "R8 prescaler");
    pre_b[3] = 0;
  endtask

  task automatic t_null;         // R1
    tbl_write(8'h00, 5'b11111);
    fire(8'h00);
    watch(5'b00000, 10, "R1 null code");
  endtask

  task automatic t_width0;       // R5
    dly_b[0] = 2; wid_b[0] = 0;
    fire(8'h11);
    watch(5'b00000, 10, "R5 zero width");
    wid_b[0] = 2;
  endtask

  task automatic t_delay0;       // R6
    tbl_write(8'h44, 5'b00100);
    dly_b[2] = 0; wid_b[2] = 3;
    fire(8'h44);
    watch(5'b00100, 8, "R6 zero delay");
  endtask

  task automatic t_pol;          // R7
    tbl_write(8'h55, 5'b00010);
    dly_b[1] = 2; wid_b[1] = 2;
    @(negedge clk); pol_cfg = 4'b0010;
    @(negedge clk);
    fire(8'h55);
    watch(5'b00010, 8, "R7 polarity");
    pol_cfg = 4'b0000;
    @(negedge clk);
  endtask

  task automatic t_retrig;       // R9
    dly_b[0] = 4; wid_b[0] = 2;
    fire(8'h11);
    fire(8'h11);
    watch(5'b00001, 12, "R9 retrigger");
  endtask

  task automatic t_remap;        // R2
    tbl_write(8'h11, 5'b01000);
    dly_b[3] = 1; wid_b[3] = 1;
    fire(8'h11);
    watch(5'b01000, 8, "R2 remap");
  endtask

  task automatic t_reset_pending; // R11
    dly_b[3] = 5;
    fire(8'h11);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    watch(5'b00000, 12, "R11 reset pending");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      dly_b[i] = 0; wid_b[i] = 1; pre_b[i] = 0;
    end
    pol_cfg = 4'b0000;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int a = 0; a < 256; a++) tbl_write(8'(a), 5'b00000);
    t_reset_state();
    t_basic();
    t_multi();
    t_presc();
    t_null();
    t_width0();
    t_delay0();
    t_pol();
    t_retrig();
    t_remap();
    t_reset_pending();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule